// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block is the transmit half of an asynchronous serial port. Software writes a control byte that sets the frame format. It then writes characters into a holding register. A shift register sends each character on the serial line as a frame: a low start bit, the data bits least significant first, an optional parity or ninth bit, and a high stop bit. The shift register moves one bit for each one-cycle baud strobe, which comes from an external rate generator.

The holding register and the shift register form two stages. A new character can therefore be written while the previous one is still being sent, and frames follow each other with no idle gap. A buffer-empty flag tells software when the holding register can take the next character. A loopback setting sends the frame to the receiver's input path instead of the pin, using nine-bit framing.

Top module: `usart_tx_frame`

## Requirements
- R1: After reset, `tx_line` is 1, `hold_empty` is 1 and the control byte is 0. A character sent with no control write uses eight data bits with no parity.
- R2: The control byte has these fields: bit 0 enables parity, bit 1 is the low select bit, bit 2 is the high select bit, and bits 4:3 are the length code. Bits 7:5 are ignored. Length code 00 sends eight data bits. With parity off the frame is 10 bits long: start 0, data LSB first, stop 1.
- R3: Length code 01 sends data bits 6:0 only. Data bit 7 is ignored.
- R4: Length code 10 sends eight data bits followed by control bit 1 as a ninth data bit. No parity bit is added, even when parity is enabled.
- R5: With parity enabled in 7-bit or 8-bit mode, a bit is added after the data. Select code {bit2,bit1} 00 makes the count of ones in data plus parity odd. Code 01 makes that count even. Code 10 sends a constant 1 and code 11 sends a constant 0.
- R6: Length code 11 uses nine-bit framing. The frame appears on `rx_feed` and `tx_line` stays 1. For any other length code, `rx_feed` follows `rx_pin`.
- R7: A write to the holding register clears `hold_empty` on the next cycle. `hold_empty` is set again when the character moves into the shift register.
- R8: When the shift register is idle, the character moves on the first strobe after the cycle of the write. The start bit then appears on the cycle after that strobe. A strobe in the same cycle as the write does not move the character. When a frame is in progress, a waiting character moves at the strobe that ends the stop bit, so the next start bit follows with no gap.
- R9: A control write during a frame leaves that frame unchanged. The new format applies from the next loaded character.
- R10: The serial line is high while idle. It changes only on the cycle after a strobe, so each bit lasts one strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| ctl_wr | input | 1 | Control byte write enable |
| ctl_wdata | input | 8 | Control byte value |
| hold_wr | input | 1 | Holding register write enable |
| hold_wdata | input | 8 | Character to send |
| rx_pin | input | 1 | External receive pin |
| tx_line | output | 1 | Serial output pin |
| rx_feed | output | 1 | Receiver input path (pin, or transmitter in loopback) |
| hold_empty | output | 1 | Holding register can accept a character |

## Verification
`hold_empty` changes one cycle after the edge that samples a write or a transfer. A start bit shows on the line one cycle after the strobe that loads it, and each later bit follows exactly one strobe period after the one before. The bench drives strobes every four cycles and makes all writes at falling edges. Its monitor samples the line at the first falling edge of each bit, taking the frame order from the expected queue. Back-to-back frames are also checked to start exactly one frame length of strobe periods after the previous start. The reset state, the flag timing and the transfer delay are checked at fixed falling edges counted from a write that coincides with a strobe.

// File: rtl/usart_tx_frame.sv
module usart_tx_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              rx_pin,
  output logic              tx_line,
  output logic              rx_feed,
  output logic              hold_empty
);
  localparam int FRM_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRM_W + 1);

  logic [4:0]        ctl;
  logic [DATA_W-1:0] hold;
  logic [FRM_W-1:0]  sh, frame;
  logic [CNT_W-1:0]  cnt, frame_len;
  logic              busy, line, load, nine, seven, loop, xbit, par;
  logic [DATA_W-1:0] pdata;

  assign busy  = cnt != '0;
  assign line  = busy ? sh[0] : 1'b1;
  assign load  = baud_tick && !hold_empty && (!busy || cnt == CNT_W'(1));
  assign nine  = ctl[4];
  assign seven = ctl[4:3] == 2'b01;
  assign loop  = ctl[4:3] == 2'b11;
  assign pdata = seven ? {1'b0, hold[DATA_W-2:0]} : hold;
  assign par   = ctl[2] ? ~ctl[1] : (ctl[1] ? ^pdata : ~^pdata);
  assign xbit  = nine ? ctl[1] : par;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    if (seven) begin
      frame[DATA_W-1:1] = hold[DATA_W-2:0];
      if (ctl[0]) frame[DATA_W] = xbit;
      frame_len = CNT_W'(DATA_W + 1 + {3'b0, ctl[0]});
    end else begin
      frame[DATA_W:1] = hold;
      if (nine || ctl[0]) frame[DATA_W+1] = xbit;
      frame_len = CNT_W'(DATA_W + 2 + {3'b0, nine || ctl[0]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
      hold <= '0;
      hold_empty <= 1'b1;
      sh <= '1;
      cnt <= '0;
    end else begin
      if (ctl_wr) ctl <= ctl_wdata[4:0];
      if (load) begin
        sh <= frame;
        cnt <= frame_len;
        hold_empty <= 1'b1;
      end else if (baud_tick && busy) begin
        sh <= {1'b1, sh[FRM_W-1:1]};
        cnt <= cnt - CNT_W'(1);
      end
      if (hold_wr) begin
        hold <= hold_wdata;
        hold_empty <= 1'b0;
      end
    end
  end

  assign tx_line = loop ? 1'b1 : line;
  assign rx_feed = loop ? line : rx_pin;

  a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !hold_empty);
  a_r7_empty_sets_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(baud_tick));
  a_r8_start_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && !hold_empty && !busy) |=> (busy && !line));
  a_r10_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(line));
  a_r6_loop_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && loop) |-> tx_line);
endmodule

// File: tb/tb_usart_tx_frame.sv
module tb_usart_tx_frame;
  localparam int DIV = 4;
  typedef struct { logic [10:0] bits; int n; bit b2b; string req; } frame_t;

  logic clk = 0, rst_n = 0, baud_tick = 0, ctl_wr = 0, hold_wr = 0, rx_pin = 1;
  logic [7:0] ctl_wdata = 0, hold_wdata = 0;
  logic tx_line, rx_feed, hold_empty;
  int checks = 0, errors = 0, cyc = 0;
  logic [4:0] cur_ctl = 0;
  bit mon_loop = 0;
  frame_t q[$];

  usart_tx_frame dut (.clk, .rst_n, .baud_tick, .ctl_wr, .ctl_wdata, .hold_wr,
    .hold_wdata, .rx_pin, .tx_line, .rx_feed, .hold_empty);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #2;
      c = (c + 1) % DIV;
      baud_tick = (c == DIV - 1);
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic frame_t mk(logic [4:0] c, logic [7:0] d, bit b2b, string req);
    frame_t f;
    int dl, ones = 0;
    bit has;
    dl = (c[4:3] == 2'b01) ? 7 : (c[4] ? 9 : 8);
    f.bits = '1;
    f.bits[0] = 0;
    for (int i = 0; i < dl; i++) begin
      f.bits[1+i] = (i == 8) ? c[1] : d[i];
      if (i < 8 && d[i]) ones++;
    end
    has = (dl != 9) && c[0];
    if (has)
      case (c[2:1])
        2'b00: f.bits[1+dl] = (ones % 2 == 0);
        2'b01: f.bits[1+dl] = (ones % 2 == 1);
        2'b10: f.bits[1+dl] = 1'b1;
        default: f.bits[1+dl] = 1'b0;
      endcase
    f.n = dl + 2 + (has ? 1 : 0);
    f.b2b = b2b;
    f.req = req;
    return f;
  endfunction

  // monitor: scoreboard pop and compare
  bit inf = 0;
  int k = 0, ph = 0, start_cyc = 0, prev_start = 0, prev_n = 0;
  frame_t cur;
  wire mline = mon_loop ? rx_feed : tx_line;
  always @(negedge clk) if (rst_n) begin
    if (!inf && mline == 1'b0) begin
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual=start expected=idle at cycle %0d", cyc);
      end else begin
        cur = q.pop_front();
        inf = 1; k = 0; ph = 0;
        start_cyc = cyc;
        if (cur.b2b) begin
          checks++;
          if (start_cyc != prev_start + prev_n * DIV) begin
            errors++;
            $display("FAIL R8 back-to-back start actual=%0d expected=%0d",
                     start_cyc, prev_start + prev_n * DIV);
          end
        end
      end
    end
    if (inf) begin
      if (ph == 0) begin
        check(cur.req, mline, cur.bits[k]);
        if (mon_loop) check("R6", tx_line, 1'b1);
        k++;
        if (k == cur.n) begin
          inf = 0; prev_start = start_cyc; prev_n = cur.n;
        end
      end
      ph = (ph + 1) % DIV;
    end
  end

  task automatic wr_ctl(logic [7:0] v);
    @(negedge clk); ctl_wr = 1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 0;
    cur_ctl = v[4:0];
  endtask

  task automatic send(logic [7:0] d, bit b2b, string req);
    @(negedge clk);
    while (!hold_empty) @(negedge clk);
    q.push_back(mk(cur_ctl, d, b2b, req));
    hold_wr = 1; hold_wdata = d;
    @(negedge clk); hold_wr = 0;
  endtask

  task automatic drain();
    while (q.size() != 0 || inf || !hold_empty) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tx_line, 1'b1);
    check("R1", hold_empty, 1'b1);
    rst_n = 1;
    @(negedge clk);
    rx_pin = 0; #1 check("R6", rx_feed, 1'b0);
    rx_pin = 1; #1 check("R6", rx_feed, 1'b1);

    // R8 / R7 timing: write in a strobe cycle, default format (R1)
    @(negedge clk);
    while (baud_tick !== 1'b1) @(negedge clk);
    q.push_back(mk(5'b0, 8'hA5, 0, "R1"));
    hold_wr = 1; hold_wdata = 8'hA5;
    @(negedge clk); hold_wr = 0;
    check("R7", hold_empty, 1'b0);
    repeat (3) @(negedge clk);
    check("R8", tx_line, 1'b1);
    @(negedge clk);
    check("R8", tx_line, 1'b0);
    check("R7", hold_empty, 1'b1);
    drain();

    send(8'h3C, 0, "R2");
    drain();
    wr_ctl(8'hE0);  // upper bits ignored, stays 8N1
    send(8'h81, 0, "R2");
    drain();

    for (int s = 0; s < 4; s++) begin
      wr_ctl({3'b0, 2'b00, s[1:0], 1'b1});
      send(8'h53, 0, "R5");
      send(8'h52, 1, "R5");
      drain();
    end

    wr_ctl(8'b000_01_01_1);  // 7-bit even parity
    send(8'hD3, 0, "R3");
    send(8'h7F, 1, "R3");
    drain();
    wr_ctl(8'b000_01_00_0);
    send(8'h80, 0, "R3");
    drain();

    wr_ctl(8'b000_10_01_1);  // 9-bit, ninth=1, parity ignored
    send(8'h5A, 0, "R4");
    drain();
    wr_ctl(8'b000_10_00_1);
    send(8'hFF, 0, "R4");
    send(8'h00, 1, "R8");
    send(8'h96, 1, "R8");
    drain();

    // R9: format change mid-frame
    wr_ctl(8'h00);
    send(8'hC3, 0, "R9");
    while (!hold_empty) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
    wr_ctl(8'b000_01_00_1);  // 7-bit odd
    send(8'hC3, 1, "R9");
    drain();

    // R6 loopback
    wr_ctl(8'b000_11_01_0);
    mon_loop = 1;
    send(8'h6E, 0, "R6");
    send(8'h11, 1, "R6");
    drain();
    check("R6", tx_line, 1'b1);
    mon_loop = 0;
    wr_ctl(8'h00);
    check("R10", tx_line, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule